// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block moves an 18-bit word between an A side and a B side, one storage word per direction. Each direction has three controls: a latch enable, a device clock and an output enable. Together they select one of three modes. With the latch enable high, the path is transparent. With the latch enable low and the device clock steady, the path holds its word. With the latch enable low, a falling device clock loads a new word. Each side presents its data on a plain output bus and a separate drive-enable flag, so an I/O ring or a mux outside the block can decide what reaches the wire.

All logic runs on one fast system clock. The latch enable and device clock of each direction are sampled as ordinary synchronous inputs. A device clock edge is recognised when one sample reads 1 and the next reads 0, and the stored word updates in the system cycle after that second sample. The transparent path is a storage word that reloads on every system cycle while the sampled latch enable is high, so the output trails the input by one system cycle. The A-to-B enable is active high and the B-to-A enable is active low.

Top module: `ubr_xcvr`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both stored words become zero, so `b_out` and `a_out` read 0 after that edge. Reset does not touch the drive-enable flags.
- R2: When `ab_le` was high at the previous edge, `b_out` after an edge equals the `a_in` value present at that edge (transparent, one cycle behind).
- R3: When `ab_le` was low at the previous edge and no falling `ab_clk` was seen, `b_out` keeps its value whatever `a_in` does.
- R4: With `ab_le` low, an `ab_clk` sampled 1 at edge k and 0 at edge k+1 makes `b_out` take the `a_in` present at edge k+2.
- R5: `b_vld` equals `ab_oe` as sampled at the previous edge (1 = drive, active high), during reset as well. `b_out` keeps carrying the stored word while `b_vld` is 0.
- R6: The B-to-A path follows R2, R3 and R4 using `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R7: `a_vld` equals the inverse of `ba_oe_n` as sampled at the previous edge (0 on `ba_oe_n` = drive, active low), during reset as well.
- R8: A falling device clock seen while the latch enable is high has no effect beyond the transparent reload.
- R9: When the latch enable drops while the device clock is already low, the output keeps the last transparently loaded word until a later falling device clock.
- R10: The two directions are independent: the controls of one never change the data or flag of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the stored words |
| a_in | input | 18 | Word arriving from the A side |
| b_in | input | 18 | Word arriving from the B side |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_clk | input | 1 | A-to-B device clock, falling edge loads |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_clk | input | 1 | B-to-A device clock, falling edge loads |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word presented to the B side |
| b_vld | output | 1 | B side drive enable |
| a_out | output | 18 | Word presented to the A side |
| a_vld | output | 1 | A side drive enable |

## Verification
The bench targets the latch enable dropping while the device clock is already low. A design that treats the level change as a load would pick up the newer input instead of holding the last transparent word. It also drives falling device clocks while the latch enable is high, where a design that gave the edge priority would load a word at the wrong cycle. The one-cycle capture delay after a falling sample is checked at the exact cycle, which exposes an off-by-one edge detector. The opposite enable polarities are checked on each side, as is the rule that reset leaves the flags alone, so a swapped polarity or a flag cleared by reset is reported. A long pseudo-random sweep of all six control inputs, compared every cycle against a bench model, catches crosstalk between the two directions.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  localparam int unsigned UBR_WIDTH = 18;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_FLOW    = 2'd1,
    MODE_CAPTURE = 2'd2
  } ubr_mode_e;

  function automatic ubr_mode_e ubr_pick_mode(input logic le_s, input logic fall_s);
    if (le_s)        return MODE_FLOW;
    else if (fall_s) return MODE_CAPTURE;
    else             return MODE_HOLD;
  endfunction

endpackage

// File: rtl/ubr_edge_sync.sv
module ubr_edge_sync (
  input  logic clk,
  input  logic le_in,
  input  logic dclk_in,
  output logic le_s,
  output logic fall_s
);
  logic dclk_cur;
  logic dclk_prev;

  always_ff @(posedge clk) begin
    le_s      <= le_in;
    dclk_cur  <= dclk_in;
    dclk_prev <= dclk_cur;
  end

  assign fall_s = dclk_prev & ~dclk_cur;
endmodule

// File: rtl/ubr_word_store.sv
module ubr_word_store #(
  parameter int unsigned W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  ubr_pkg::ubr_mode_e mode,
  input  logic [W-1:0]       d,
  output logic [W-1:0]       q
);
  import ubr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (mode)
        MODE_FLOW, MODE_CAPTURE: q <= d;
        default:                 q <= q;
      endcase
    end
  end
endmodule

// File: rtl/ubr_dir.sv
module ubr_dir #(
  parameter int unsigned W       = 18,
  parameter bit          OE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         dclk,
  input  logic         oe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  import ubr_pkg::*;

  logic      le_s;
  logic      fall_s;
  logic      oe_act;
  ubr_mode_e mode;

  ubr_edge_sync u_sync (
    .clk     (clk),
    .le_in   (le),
    .dclk_in (dclk),
    .le_s    (le_s),
    .fall_s  (fall_s)
  );

  always_comb mode = ubr_pick_mode(le_s, fall_s);

  ubr_word_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .d    (d),
    .q    (q)
  );

  generate
    if (OE_HIGH) begin : g_oe_hi
      assign oe_act = oe;
    end else begin : g_oe_lo
      assign oe_act = ~oe;
    end
  endgenerate

  always_ff @(posedge clk) begin
    vld <= oe_act;
  end
endmodule

// File: rtl/ubr_xcvr.sv
module ubr_xcvr #(
  parameter int unsigned W = ubr_pkg::UBR_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_vld,
  output logic [W-1:0] a_out,
  output logic         a_vld
);
  ubr_dir #(.W(W), .OE_HIGH(1'b1)) u_ab (
    .clk  (clk),
    .rst  (rst),
    .le   (ab_le),
    .dclk (ab_clk),
    .oe   (ab_oe),
    .d    (a_in),
    .q    (b_out),
    .vld  (b_vld)
  );

  ubr_dir #(.W(W), .OE_HIGH(1'b0)) u_ba (
    .clk  (clk),
    .rst  (rst),
    .le   (ba_le),
    .dclk (ba_clk),
    .oe   (ba_oe_n),
    .d    (b_in),
    .q    (a_out),
    .vld  (a_vld)
  );
endmodule

// File: rtl/ubr_xcvr_chk.sv
module ubr_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic [W-1:0] b_out,
  input logic         b_vld,
  input logic [W-1:0] a_out,
  input logic         a_vld
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (b_out == '0 && a_out == '0)); // R1

  AST_BVLD_POL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_vld == $past(ab_oe))); // R5

  AST_AVLD_POL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_vld == !$past(ba_oe_n))); // R7

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_le, 2) && !($past(ab_clk, 3) && !$past(ab_clk, 2)))
      |-> $stable(b_out)); // R3

  AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(ab_le, 2) || ($past(ab_clk, 3) && !$past(ab_clk, 2))))
      |-> (b_out == $past(a_in))); // R4

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ba_le, 2) && !($past(ba_clk, 3) && !$past(ba_clk, 2)))
      |-> $stable(a_out)); // R6

  AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(ba_le, 2) || ($past(ba_clk, 3) && !$past(ba_clk, 2))))
      |-> (a_out == $past(b_in))); // R6
endmodule

bind ubr_xcvr ubr_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b_in    (b_in),
  .ab_le   (ab_le),
  .ab_clk  (ab_clk),
  .ab_oe   (ab_oe),
  .ba_le   (ba_le),
  .ba_clk  (ba_clk),
  .ba_oe_n (ba_oe_n),
  .b_out   (b_out),
  .b_vld   (b_vld),
  .a_out   (a_out),
  .a_vld   (a_vld)
);

// File: tb/ubr_xcvr_bench.sv
`timescale 1ns/1ps
module ubr_xcvr_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
  logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic         b_vld, a_vld;

  int    n_vec  = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;
  string tag    = "R1";

  always #10 clk = ~clk;

  ubr_xcvr #(.W(W)) u_ubr_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_vld(b_vld), .a_out(a_out), .a_vld(a_vld)
  );

  // reference model built from the requirements
  logic [W-1:0] m_b = '0, m_a = '0;
  logic m_abl = 0, m_abc1 = 0, m_abc2 = 0, m_bal = 0, m_bac1 = 0, m_bac2 = 0;
  logic m_bv = 0, m_av = 0;

  always @(posedge clk) begin
    m_abl <= ab_le; m_abc1 <= ab_clk; m_abc2 <= m_abc1;
    m_bal <= ba_le; m_bac1 <= ba_clk; m_bac2 <= m_bac1;
    if (rst) m_b <= '0;
    else if (m_abl || (m_abc2 && !m_abc1)) m_b <= a_in;
    if (rst) m_a <= '0;
    else if (m_bal || (m_bac2 && !m_bac1)) m_a <= b_in;
    m_bv <= ab_oe;
    m_av <= !ba_oe_n;
  end

  task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({tag, " b_out"}, b_out, m_b);
      chk({tag, " a_out"}, a_out, m_a);
      chk("R5 b_vld", W'(b_vld), W'(m_bv));
      chk("R7 a_vld", W'(a_vld), W'(m_av));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
      finish_run();
    end
  end

  logic [31:0] lfsr = 32'h1ACE_B00C;

  initial begin
    // R1 reset, flags follow enables during reset (R5, R7)
    a_in = 18'h2DEAD; b_in = 18'h1BEEF; ab_le = 1; ba_le = 1;
    ab_oe = 1; ba_oe_n = 0;
    cyc(5);
    chk("R1 b_out reset", b_out, '0);
    chk("R1 a_out reset", a_out, '0);
    chk("R5 b_vld in reset", W'(b_vld), W'(1));
    chk("R7 a_vld in reset", W'(a_vld), W'(1));
    ab_oe = 0; ba_oe_n = 1;
    cyc(1);
    chk("R5 b_vld low", W'(b_vld), W'(0));
    chk("R7 a_vld low", W'(a_vld), W'(0));
    rst = 0;
    cmp_on = 1;

    // R2 transparent A to B, varied patterns
    tag = "R2";
    for (int i = 0; i < 24; i++) begin
      a_in = W'(32'h15555 ^ (i * 32'h0B3D1));
      cyc(1);
    end
    a_in = 18'h3FFFF; cyc(1);
    chk("R2 follow ones", b_out, 18'h3FFFF);

    // R9 latch enable drops with device clock low
    tag = "R9";
    a_in = 18'h12345; cyc(2);
    ab_le = 0; cyc(1);
    for (int i = 0; i < 5; i++) begin
      a_in = W'(i * 32'h0F0F1 + 7);
      cyc(1);
    end
    chk("R9 kept word", b_out, 18'h12345);

    // R3 hold with device clock high
    tag = "R3";
    ab_clk = 1; cyc(2);
    for (int i = 0; i < 6; i++) begin
      a_in = W'(32'h2AAAA ^ i);
      cyc(1);
    end
    chk("R3 held word", b_out, 18'h12345);

    // R4 falling device clock loads, check exact cycle
    tag = "R4";
    a_in = 18'h0C0DE; ab_clk = 0;
    cyc(1);
    chk("R4 not yet", b_out, 18'h12345);
    cyc(1);
    chk("R4 loaded", b_out, 18'h0C0DE);
    a_in = 18'h00001; cyc(3);
    chk("R4 held after load", b_out, 18'h0C0DE);

    // R5 data still carried while disabled
    chk("R5 data with oe low", b_out, 18'h0C0DE);

    // R8 falling clock while transparent
    tag = "R8";
    ab_le = 1; ab_clk = 1; cyc(2);
    for (int i = 0; i < 8; i++) begin
      a_in = W'(i * 32'h1111);
      ab_clk = ~ab_clk;
      cyc(1);
    end

    // R6 B to A directed sequence
    tag = "R6";
    b_in = 18'h0AAAA; ba_le = 1; ba_clk = 0; cyc(2);
    chk("R6 transparent", a_out, 18'h0AAAA);
    ba_le = 0; cyc(1); b_in = 18'h15555; cyc(3);
    chk("R6 hold", a_out, 18'h0AAAA);
    ba_clk = 1; cyc(2); ba_clk = 0; cyc(2);
    chk("R6 capture", a_out, 18'h15555);
    ba_oe_n = 0; cyc(1);

    // R10 pseudo-random sweep of all controls in both directions
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ab_le   = lfsr[3] & lfsr[9];
      ba_le   = lfsr[5] & lfsr[12];
      ab_clk  = lfsr[7];
      ba_clk  = lfsr[11];
      ab_oe   = lfsr[14];
      ba_oe_n = lfsr[15];
      a_in    = lfsr[17:0];
      b_in    = lfsr[31:14];
      if (i == 2000) rst = 1;
      if (i == 2003) rst = 0;
      cyc(1);
    end

    cmp_on = 0;
    finish_run();
  end
endmodule